// File: doc/BRIEF.md
# Floating-Point Exception Cause and Enable Control

This block holds the exception-tracking state of a floating-point control register. For five conditions (invalid operation, divide by zero, overflow, underflow and inexact) it keeps one enable bit and one cause bit each. When an arithmetic datapath finishes an operation, the block receives that operation's status flags together with direct invalid and divide-by-zero requests. In the same cycle it decides whether the result may be written to the destination register, and whether that result is to be replaced by a quiet NaN.

In the cycle after the operation, the block's cause field holds the single condition that was recorded for it, or no condition at all. A one-cycle trap request to the CPU goes out in that same cycle whenever a cause was recorded. Software reads and writes the control word over a plain register port.

The block has no arithmetic datapath and does no trap vectoring. The reset input is asynchronous and active low. Its release is synchronised inside the block over two clock edges.

Top module: `fpx_exc_ctrl`

## Requirements
- R1: After reset the control word reads zero, `trap_req` is low, and `wb_commit` and `wb_qnan` are low while `op_valid` is low.
- R2: Every operation (`op_valid` high) clears all five cause bits and then records at most one new cause. The result shows on `reg_rdata` in the following cycle.
- R3: `op_invalid` takes priority over every other input. With the invalid enable set, the invalid cause is recorded and no writeback happens. With it clear, no cause is recorded, and `wb_commit` and `wb_qnan` are both high.
- R4: When `op_invalid` is low and `op_divzero` is high with the divide-by-zero enable set, the divide-by-zero cause is recorded. With that enable clear, the request has no effect and the status checks decide.
- R5: Overflow status (`op_status` bit 0) with the overflow enable set records only the overflow cause. Any lower status flags of the same operation are ignored.
- R6: Underflow status (bit 1) or denormal status (bit 2), with the underflow enable set, records the underflow cause. This holds only when overflow was not recorded.
- R7: Inexact status (bit 3) or rounded status (bit 4), with the inexact enable set, records the inexact cause. This holds only when neither overflow nor underflow was recorded.
- R8: `wb_commit` is high during an operation's cycle exactly when that operation records no cause.
- R9: `trap_req` is a one-cycle pulse in the cycle after an operation that recorded a cause. It is never raised at any other time.
- R10: Control word layout. The enable bits sit at bits 4:0 and the cause bits at bits 12:8, in the order inexact=+0, underflow=+1, overflow=+2, divide-by-zero=+3, invalid=+4. All other bits read zero. A write shows on `reg_rdata` in the next cycle.
- R11: When a register write and an operation occur in the same cycle, the operation is judged against the enables held before the write. The enables are then taken from the write and the causes from the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation's status is presented this cycle |
| op_status | input | 5 | Datapath flags: 0 overflow, 1 underflow, 2 denormal, 3 inexact, 4 rounded |
| op_invalid | input | 1 | Invalid-operation request |
| op_divzero | input | 1 | Divide-by-zero request |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Current control word |
| wb_commit | output | 1 | Destination register may be written this cycle |
| wb_qnan | output | 1 | Destination receives a quiet NaN instead of the result |
| trap_req | output | 1 | One-cycle exception trap request |

## Verification
The assertions assume that all inputs are known values at every sampled edge. They also assume that the condition flags have no meaning while `op_valid` is low. The bench never leaves an input undriven once reset is released. It starts operations only after the internal reset release has completed.

The sweep covers every combination of the five enables with the invalid request, the divide-by-zero request and all five status flags. It starts each operation with a cause field preloaded to all ones, so that a clear which fails to happen becomes visible.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NFLG  = 5;
  localparam int NSTAT = 5;

  // flag order inside the enable and cause fields
  localparam int F_INX = 0;
  localparam int F_UNF = 1;
  localparam int F_OVF = 2;
  localparam int F_DVZ = 3;
  localparam int F_INV = 4;

  typedef logic [NFLG-1:0] fpx_flags_t;

  typedef struct packed {
    logic rounded;
    logic inexact;
    logic denorm;
    logic underflow;
    logic overflow;
  } fpx_status_t;
endpackage

// File: rtl/fpx_cause_sel.sv
module fpx_cause_sel
  import fpx_pkg::*;
(
  input  logic        op_valid,
  input  fpx_flags_t  ena,
  input  logic        req_inv,
  input  logic        req_dvz,
  input  fpx_status_t st,
  output fpx_flags_t  cause_new,
  output logic        commit,
  output logic        qnan
);
  logic hit_ovf, hit_unf, hit_inx;

  always_comb begin
    hit_ovf = st.overflow & ena[F_OVF];
    hit_unf = (st.underflow | st.denorm) & ena[F_UNF];
    hit_inx = (st.inexact | st.rounded) & ena[F_INX];
  end

  always_comb begin
    cause_new = '0;
    qnan      = 1'b0;
    if (req_inv) begin
      if (ena[F_INV]) cause_new[F_INV] = 1'b1;
      else            qnan = 1'b1;
    end else if (req_dvz && ena[F_DVZ]) begin
      cause_new[F_DVZ] = 1'b1;
    end else if (hit_ovf) begin
      cause_new[F_OVF] = 1'b1;
    end else if (hit_unf) begin
      cause_new[F_UNF] = 1'b1;
    end else if (hit_inx) begin
      cause_new[F_INX] = 1'b1;
    end
    commit = op_valid & (cause_new == '0);
    qnan   = op_valid & qnan;
  end
endmodule

// File: rtl/fpx_ctrl_reg.sv
module fpx_ctrl_reg
  import fpx_pkg::*;
#(
  parameter int CW_W    = 32,
  parameter int ENA_LSB = 0,
  parameter int CAU_LSB = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [CW_W-1:0] reg_wdata,
  input  logic            op_valid,
  input  fpx_flags_t      cause_new,
  output fpx_flags_t      ena_q,
  output logic [CW_W-1:0] reg_rdata
);
  localparam int ENA_MSB = ENA_LSB + NFLG - 1;
  localparam int CAU_MSB = CAU_LSB + NFLG - 1;

  fpx_flags_t ena_d, cau_d, cau_q;
  logic       ena_en, cau_en;

  always_comb begin
    ena_en = reg_we;
    cau_en = reg_we | op_valid;
    ena_d  = reg_wdata[ENA_MSB:ENA_LSB];
    cau_d  = op_valid ? cause_new : reg_wdata[CAU_MSB:CAU_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
      cau_q <= '0;
    end else begin
      if (ena_en) ena_q <= ena_d;
      if (cau_en) cau_q <= cau_d;
    end
  end

  for (genvar i = 0; i < CW_W; i++) begin : g_rd
    if (i >= ENA_LSB && i <= ENA_MSB) begin : g_ena
      assign reg_rdata[i] = ena_q[i-ENA_LSB];
    end else if (i >= CAU_LSB && i <= CAU_MSB) begin : g_cau
      assign reg_rdata[i] = cau_q[i-CAU_LSB];
    end else begin : g_zero
      assign reg_rdata[i] = 1'b0;
    end
  end
endmodule

// File: rtl/fpx_trap_gen.sv
module fpx_trap_gen
  import fpx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  fpx_flags_t cause_new,
  output logic       trap_req
);
  logic trap_d, trap_q;

  always_comb trap_d = op_valid & (|cause_new);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= trap_d;
  end

  assign trap_req = trap_q;
endmodule

// File: rtl/fpx_exc_ctrl.sv
module fpx_exc_ctrl
  import fpx_pkg::*;
#(
  parameter int CW_W    = 32,
  parameter int ENA_LSB = 0,
  parameter int CAU_LSB = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [NSTAT-1:0] op_status,
  input  logic             op_invalid,
  input  logic             op_divzero,
  input  logic             reg_we,
  input  logic [CW_W-1:0]  reg_wdata,
  output logic [CW_W-1:0]  reg_rdata,
  output logic             wb_commit,
  output logic             wb_qnan,
  output logic             trap_req
);
  logic [1:0]  rst_sync;
  logic        rst_sync_n;
  fpx_flags_t  ena_q, cause_new;
  fpx_status_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  assign st = fpx_status_t'(op_status);

  fpx_cause_sel u_sel (
    .op_valid  (op_valid),
    .ena       (ena_q),
    .req_inv   (op_invalid),
    .req_dvz   (op_divzero),
    .st        (st),
    .cause_new (cause_new),
    .commit    (wb_commit),
    .qnan      (wb_qnan)
  );

  fpx_ctrl_reg #(.CW_W(CW_W), .ENA_LSB(ENA_LSB), .CAU_LSB(CAU_LSB)) u_reg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .op_valid  (op_valid),
    .cause_new (cause_new),
    .ena_q     (ena_q),
    .reg_rdata (reg_rdata)
  );

  fpx_trap_gen u_trap (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .op_valid  (op_valid),
    .cause_new (cause_new),
    .trap_req  (trap_req)
  );
endmodule

// File: rtl/fpx_exc_ctrl_chk.sv
module fpx_exc_ctrl_chk
  import fpx_pkg::*;
#(
  parameter int CW_W    = 32,
  parameter int ENA_LSB = 0,
  parameter int CAU_LSB = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic            reg_we,
  input logic [CW_W-1:0] reg_wdata,
  input logic [CW_W-1:0] reg_rdata,
  input logic            wb_commit,
  input logic            wb_qnan,
  input logic            trap_req
);
  fpx_flags_t cau, ena;
  assign cau = reg_rdata[CAU_LSB +: NFLG];
  assign ena = reg_rdata[ENA_LSB +: NFLG];

  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> $onehot0(cau)); // R2
  AST_COMMIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && wb_commit) |=> (cau == '0)); // R8
  AST_NO_COMMIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !wb_commit) |=> (cau != '0)); // R8
  AST_TRAP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (trap_req == (cau != '0))); // R9
  AST_TRAP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(op_valid)); // R9
  AST_QNAN_WB: assert property (@(posedge clk) disable iff (!rst_n)
    wb_qnan |-> (wb_commit && op_valid)); // R3
  AST_SW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !op_valid) |=> (cau == $past(reg_wdata[CAU_LSB +: NFLG]))); // R10
  AST_ENA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(ena)); // R11
endmodule

bind fpx_exc_ctrl fpx_exc_ctrl_chk #(.CW_W(CW_W), .ENA_LSB(ENA_LSB), .CAU_LSB(CAU_LSB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .op_valid  (op_valid),
  .reg_we    (reg_we),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .wb_commit (wb_commit),
  .wb_qnan   (wb_qnan),
  .trap_req  (trap_req)
);

// File: tb/fpx_exc_ctrl_bench.sv
module fpx_exc_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, op_invalid, op_divzero, reg_we;
  logic [4:0]  op_status;
  logic [31:0] reg_wdata, reg_rdata;
  logic        wb_commit, wb_qnan, trap_req;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  fpx_exc_ctrl u_fpx_exc_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_status(op_status),
    .op_invalid(op_invalid), .op_divzero(op_divzero), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wb_commit(wb_commit),
    .wb_qnan(wb_qnan), .trap_req(trap_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected cause per requirement text; bit order I,U,O,Z,V
  function automatic logic [4:0] exp_cause(input logic [4:0] en, input logic inv,
                                           input logic dz, input logic [4:0] st);
    if (inv)                      return en[4] ? 5'b10000 : 5'b0;
    if (dz && en[3])              return 5'b01000;
    if (st[0] && en[2])           return 5'b00100;
    if ((st[1] | st[2]) && en[1]) return 5'b00010;
    if ((st[3] | st[4]) && en[0]) return 5'b00001;
    return 5'b0;
  endfunction

  function automatic string tag_of(input logic [4:0] en, input logic inv,
                                   input logic dz, input logic [4:0] st);
    if (inv)                      return "R3";
    if (dz && en[3])              return "R4";
    if (st[0] && en[2])           return "R5";
    if ((st[1] | st[2]) && en[1]) return "R6";
    return "R7";
  endfunction

  task automatic one_op(input logic [4:0] en, input logic inv, input logic dz,
                        input logic [4:0] st);
    logic [4:0] ec;
    string      tg;
    ec = exp_cause(en, inv, dz, st);
    tg = tag_of(en, inv, dz, st);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = {19'd0, 5'h1F, 3'd0, en};
    @(negedge clk);
    reg_we = 1'b0;
    chk("R10 preload", reg_rdata, {19'd0, 5'h1F, 3'd0, en});
    op_valid = 1'b1; op_invalid = inv; op_divzero = dz; op_status = st;
    #1;
    chk({tg, " R8 commit"}, {31'd0, wb_commit}, {31'd0, ec == 5'd0});
    chk({tg, " qnan"}, {31'd0, wb_qnan}, {31'd0, inv & ~en[4]});
    @(negedge clk);
    op_valid = 1'b0; op_invalid = 1'b0; op_divzero = 1'b0; op_status = '0;
    chk({tg, " R2 cause"}, reg_rdata, {19'd0, ec, 3'd0, en});
    chk("R9 trap", {31'd0, trap_req}, {31'd0, ec != 5'd0});
    @(negedge clk);
    chk("R9 pulse end", {31'd0, trap_req}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_invalid = 1'b0; op_divzero = 1'b0;
    op_status = '0; reg_we = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 word", reg_rdata, 32'd0);
    chk("R1 trap", {31'd0, trap_req}, 32'd0);
    chk("R1 wb", {30'd0, wb_commit, wb_qnan}, 32'd0);

    // unused bits read zero
    reg_we = 1'b1; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R10 layout", reg_rdata, 32'h0000_1F1F);
    chk("R9 no trap on write", {31'd0, trap_req}, 32'd0);

    // exhaustive sweep of enables and condition inputs
    for (int e = 0; e < 32; e++)
      for (int c = 0; c < 128; c++)
        one_op(5'(e), c[6], c[5], c[4:0]);

    // same-cycle write and operation: old enables (0) judge overflow
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = 32'd0;
    @(negedge clk);
    reg_wdata = 32'h0000_1F1F; op_valid = 1'b1; op_status = 5'b00001;
    @(negedge clk);
    reg_we = 1'b0; op_valid = 1'b0; op_status = '0;
    chk("R11 collide old ena", reg_rdata, 32'h0000_001F);
    chk("R11 no trap", {31'd0, trap_req}, 32'd0);
    // next operation sees new enables
    op_valid = 1'b1; op_status = 5'b00011;
    @(negedge clk);
    op_valid = 1'b0; op_status = '0;
    chk("R5 after collide", reg_rdata, 32'h0000_041F);
    chk("R9 trap", {31'd0, trap_req}, 32'd1);
    // write causes all ones while a clean op runs: op wins causes
    reg_we = 1'b1; reg_wdata = 32'h0000_1F1F; op_valid = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; op_valid = 1'b0;
    chk("R11 op causes win", reg_rdata, 32'h0000_001F);
    chk("R9 clean op", {31'd0, trap_req}, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule